// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block sets the frame timing of a time-division-multiplexed audio port. In master mode it divides the system clock down to a serial bit clock. It counts bit positions inside a frame of programmable length and drives a frame sync pulse in one of three shapes. In slave mode it takes the bit clock and the frame sync from the pins, brings both into the system clock domain, and aligns its bit counter to the rising edge of the incoming sync.

A serializer next to the block uses the frame-start strobe, the bit position counter and the two edge strobes. One strobe marks when transmit data must change and the other marks when receive data must be sampled. Before the block runs, the frame length is checked against the slot geometry: the widest slot and the largest slot count of the two directions. An impossible combination is flagged, and the generator stays idle while the flag is set.

Top module: `tdm_fsync_gen`

## Requirements
- R1: After reset, and while the enable bit is 0, `bclk_o`, `fsync_o`, `frame_start_o`, `tx_shift_o`, `rx_sample_o`, `port_drive_o` and `bit_cnt_o` are all 0.
- R2: In master mode, `bclk_o` toggles every `BCLK_HALF` system clocks, so every rising edge after the first follows the one before by 2*`BCLK_HALF` cycles.
- R3: At each bit clock rising edge, `bit_cnt_o` advances and wraps from `frame_div` back to 0, so a frame is `frame_div`+1 bits long. The first rising edge after enable gives bit 0. `frame_start_o` pulses for one system cycle exactly when bit 0 begins.
- R4: Short sync, late (ctrl bit 2 = 0, bit 3 = 0): `fsync_o` is high only during bit 0.
- R5: Short sync, early (ctrl bit 2 = 0, bit 3 = 1): `fsync_o` is high only during the last bit of the frame (`bit_cnt_o` = `frame_div`), one bit clock ahead of bit 0.
- R6: Long sync (ctrl bit 2 = 1): `fsync_o` is high for bits 0 to L-1, where L is the larger of `tx_slot_bits` and `rx_slot_bits`. The early/late bit has no effect in this mode.
- R7: Let S be the larger slot count of the two directions. `config_error_o` is 1 when `frame_div`+1 < L*S. While it is 1, the generator stays idle as in R1 even when enabled.
- R8: In long sync with S <= 1, `config_error_o` is also 1 when `frame_div`+1 <= L. The same setting in short sync raises no error.
- R9: Ctrl bit 5 = 0 makes `tx_shift_o` pulse on each bit clock rising edge and `rx_sample_o` on each falling edge. Ctrl bit 5 = 1 swaps the two edges.
- R10: In slave mode (ctrl bit 1 = 1), a rising edge of `ext_fsync` sampled at a `ext_bclk` rising edge restarts `bit_cnt_o` at 0 and pulses `frame_start_o` once. A sync held high for several bits gives only one frame start. `bclk_o`, `fsync_o` and `port_drive_o` stay 0 in this mode.
- R11: The control word fields are: bit 0 enable, bit 1 slave, bit 2 long sync, bit 3 early, bit 4 transmit float request, bit 5 clock polarity. `tx_hiz_o` is 1 when bit 4 is set and the generator is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 6 | Control fields, layout in R11 |
| frame_div | input | DIV_W | Frame length minus one, in bits |
| tx_slot_bits | input | SLOT_W | Transmit slot length in bits |
| rx_slot_bits | input | SLOT_W | Receive slot length in bits |
| tx_slots | input | NSLOT_W | Transmit slot count |
| rx_slots | input | NSLOT_W | Receive slot count |
| ext_bclk | input | 1 | Bit clock from the pin (slave mode) |
| ext_fsync | input | 1 | Frame sync from the pin (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| fsync_o | output | 1 | Generated frame sync (master mode) |
| port_drive_o | output | 1 | Clock and sync pins driven by this block |
| frame_start_o | output | 1 | One-cycle strobe at bit 0 of a frame |
| bit_cnt_o | output | DIV_W | Bit position inside the frame |
| tx_shift_o | output | 1 | Strobe: transmit data changes now |
| rx_sample_o | output | 1 | Strobe: sample receive data now |
| config_error_o | output | 1 | Frame length conflicts with slot geometry |
| tx_hiz_o | output | 1 | Transmit line should float |

## Verification
In master mode the bench tries random slot lengths and counts per direction, frame lengths at and just above the geometry minimum, and all combinations of sync shape, early/late and polarity. At every observed bit clock edge the sync level and the bit position are checked against a reference model. This separates the three sync shapes, catches an off-by-one in the frame wrap, and shows whether the early bit leaks into long mode. Directed settings just below the minimum, and a long single-slot frame exactly one slot wide, separate the two error rules from each other and from the short-mode case. A slave run drives a one-bit sync pattern and then a half-frame-wide sync pattern. This shows that only the rising edge realigns the counter.

// File: rtl/tdm_fsync_pkg.sv
package tdm_fsync_pkg;

  localparam int CTRL_W  = 6;
  localparam int EN_B    = 0;
  localparam int SLV_B   = 1;
  localparam int LONG_B  = 2;
  localparam int EARLY_B = 3;
  localparam int HIZ_B   = 4;
  localparam int POL_B   = 5;

  typedef enum logic [1:0] {
    FS_SHORT_LATE  = 2'd0,
    FS_SHORT_EARLY = 2'd1,
    FS_LONG        = 2'd2
  } fs_kind_e;

  function automatic fs_kind_e decode_kind(input logic long_m, input logic early_m);
    if (long_m)       return FS_LONG;
    else if (early_m) return FS_SHORT_EARLY;
    else              return FS_SHORT_LATE;
  endfunction

endpackage

// File: rtl/tdm_cfg_check.sv
module tdm_cfg_check #(
  parameter int DIV_W   = 10,
  parameter int SLOT_W  = 6,
  parameter int NSLOT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   frame_div,
  input  logic [SLOT_W-1:0]  tx_slot_bits,
  input  logic [SLOT_W-1:0]  rx_slot_bits,
  input  logic [NSLOT_W-1:0] tx_slots,
  input  logic [NSLOT_W-1:0] rx_slots,
  input  logic               long_mode,
  output logic [SLOT_W-1:0]  slot_len,
  output logic               cfg_err
);

  localparam int PROD_W = SLOT_W + NSLOT_W;
  localparam int CMP_W  = (DIV_W + 1 > PROD_W) ? DIV_W + 1 : PROD_W;

  logic [SLOT_W-1:0]  len_max;
  logic [NSLOT_W-1:0] cnt_max;
  logic [PROD_W-1:0]  need_bits;
  logic [CMP_W-1:0]   frame_len;
  logic               short_frame;
  logic               thin_long;
  logic               err_d;
  logic [SLOT_W-1:0]  len_q;
  logic               err_q;

  always_comb begin
    len_max     = (tx_slot_bits >= rx_slot_bits) ? tx_slot_bits : rx_slot_bits;
    cnt_max     = (tx_slots >= rx_slots) ? tx_slots : rx_slots;
    need_bits   = PROD_W'(len_max) * PROD_W'(cnt_max);
    frame_len   = CMP_W'(frame_div) + CMP_W'(1);
    short_frame = frame_len < CMP_W'(need_bits);
    thin_long   = long_mode && (cnt_max <= NSLOT_W'(1)) && (frame_len <= CMP_W'(len_max));
    err_d       = short_frame || thin_long;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      err_q <= 1'b0;
    end else begin
      len_q <= len_max;
      err_q <= err_d;
    end
  end

  assign slot_len = len_q;
  assign cfg_err  = err_q;

endmodule

// File: rtl/tdm_bclk_src.sv
module tdm_bclk_src #(
  parameter int BCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic slave,
  input  logic ext_bclk,
  input  logic ext_fsync,
  output logic bclk_q,
  output logic rise_evt,
  output logic fall_evt,
  output logic fs_smp
);

  localparam int HC_W = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(BCLK_HALF - 1);

  logic [HC_W-1:0] hc_q, hc_d;
  logic            bclk_d;
  logic            m_tick;
  logic            bs1_q, bs2_q, bs3_q;
  logic            fs1_q, fs2_q;

  // master divider: next state
  always_comb begin
    hc_d   = hc_q;
    bclk_d = bclk_q;
    m_tick = 1'b0;
    if (!active || slave) begin
      hc_d   = '0;
      bclk_d = 1'b0;
    end else if (hc_q == HC_LAST) begin
      hc_d   = '0;
      bclk_d = ~bclk_q;
      m_tick = 1'b1;
    end else begin
      hc_d   = hc_q + HC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      bclk_q <= 1'b0;
    end else begin
      hc_q   <= hc_d;
      bclk_q <= bclk_d;
    end
  end

  // pin synchronizers for slave mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bs1_q <= 1'b0;
      bs2_q <= 1'b0;
      bs3_q <= 1'b0;
      fs1_q <= 1'b0;
      fs2_q <= 1'b0;
    end else begin
      bs1_q <= ext_bclk;
      bs2_q <= bs1_q;
      bs3_q <= bs2_q;
      fs1_q <= ext_fsync;
      fs2_q <= fs1_q;
    end
  end

  always_comb begin
    if (slave) begin
      rise_evt = active && bs2_q && !bs3_q;
      fall_evt = active && !bs2_q && bs3_q;
    end else begin
      rise_evt = m_tick && !bclk_q;
      fall_evt = m_tick && bclk_q;
    end
    fs_smp = fs2_q;
  end

  // R2
  master_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !slave && $past(active) && !$past(slave) && !m_tick) |=> $stable(bclk_q));

endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_fsync_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              slave,
  input  logic              pol,
  input  fs_kind_e          kind,
  input  logic [DIV_W-1:0]  frame_div,
  input  logic [SLOT_W-1:0] slot_len,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              fs_smp,
  output logic [DIV_W-1:0]  bit_cnt,
  output logic              fsync,
  output logic              frame_start,
  output logic              tx_shift,
  output logic              rx_sample
);

  localparam int CW = (DIV_W > SLOT_W) ? DIV_W : SLOT_W;

  logic [DIV_W-1:0] cnt_q, cnt_d, cnt_wrap;
  logic             fs_q, fs_d;
  logic             fst_q, fst_d;
  logic             run_q, run_d;
  logic             fsp_q, fsp_d;
  logic             tx_q, tx_d, rx_q, rx_d;

  function automatic logic sync_level(input fs_kind_e k, input logic [DIV_W-1:0] n,
                                      input logic [DIV_W-1:0] last,
                                      input logic [SLOT_W-1:0] len);
    case (k)
      FS_SHORT_EARLY: return n == last;
      FS_LONG:        return CW'(n) < CW'(len);
      default:        return n == '0;
    endcase
  endfunction

  always_comb begin
    cnt_wrap = (cnt_q >= frame_div) ? '0 : cnt_q + DIV_W'(1);
    cnt_d    = cnt_q;
    fs_d     = fs_q;
    fst_d    = 1'b0;
    run_d    = run_q;
    fsp_d    = fsp_q;
    tx_d     = 1'b0;
    rx_d     = 1'b0;
    if (!active) begin
      cnt_d = '0;
      fs_d  = 1'b0;
      run_d = 1'b0;
      fsp_d = 1'b0;
    end else begin
      tx_d = pol ? fall_evt : rise_evt;
      rx_d = pol ? rise_evt : fall_evt;
      if (slave) begin
        fs_d = 1'b0;
        if (rise_evt) begin
          fsp_d = fs_smp;
          if (fs_smp && !fsp_q) begin
            cnt_d = '0;
            fst_d = 1'b1;
            run_d = 1'b1;
          end else if (run_q) begin
            cnt_d = cnt_wrap;
          end
        end
      end else if (rise_evt) begin
        cnt_d = run_q ? cnt_wrap : '0;
        run_d = 1'b1;
        fst_d = (cnt_d == '0);
        fs_d  = sync_level(kind, cnt_d, frame_div, slot_len);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fs_q  <= 1'b0;
      fst_q <= 1'b0;
      run_q <= 1'b0;
      fsp_q <= 1'b0;
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fs_q  <= fs_d;
      fst_q <= fst_d;
      run_q <= run_d;
      fsp_q <= fsp_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
    end
  end

  assign bit_cnt     = cnt_q;
  assign fsync       = fs_q;
  assign frame_start = fst_q;
  assign tx_shift    = tx_q;
  assign rx_sample   = rx_q;

  // R3
  frame_start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fst_q |-> (cnt_q == '0));

  // R4
  late_pulse_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && kind == FS_SHORT_LATE && !slave && $stable(kind)) |-> (cnt_q == '0));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_q && rx_q));

endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
  import tdm_fsync_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int SLOT_W    = 6,
  parameter int NSLOT_W   = 4,
  parameter int BCLK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [5:0]         ctrl_word,
  input  logic [DIV_W-1:0]   frame_div,
  input  logic [SLOT_W-1:0]  tx_slot_bits,
  input  logic [SLOT_W-1:0]  rx_slot_bits,
  input  logic [NSLOT_W-1:0] tx_slots,
  input  logic [NSLOT_W-1:0] rx_slots,
  input  logic               ext_bclk,
  input  logic               ext_fsync,
  output logic               bclk_o,
  output logic               fsync_o,
  output logic               port_drive_o,
  output logic               frame_start_o,
  output logic [DIV_W-1:0]   bit_cnt_o,
  output logic               tx_shift_o,
  output logic               rx_sample_o,
  output logic               config_error_o,
  output logic               tx_hiz_o
);

  logic              en, slave, long_m, early_m, hiz_req, pol;
  fs_kind_e          kind;
  logic              cfg_err;
  logic              active;
  logic [SLOT_W-1:0] slot_len;
  logic              bclk_q, rise_evt, fall_evt, fs_smp;

  always_comb begin
    en      = ctrl_word[EN_B];
    slave   = ctrl_word[SLV_B];
    long_m  = ctrl_word[LONG_B];
    early_m = ctrl_word[EARLY_B];
    hiz_req = ctrl_word[HIZ_B];
    pol     = ctrl_word[POL_B];
    kind    = decode_kind(long_m, early_m);
    active  = en && !cfg_err;
  end

  tdm_cfg_check #(
    .DIV_W  (DIV_W),
    .SLOT_W (SLOT_W),
    .NSLOT_W(NSLOT_W)
  ) i_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_div   (frame_div),
    .tx_slot_bits(tx_slot_bits),
    .rx_slot_bits(rx_slot_bits),
    .tx_slots    (tx_slots),
    .rx_slots    (rx_slots),
    .long_mode   (long_m),
    .slot_len    (slot_len),
    .cfg_err     (cfg_err)
  );

  tdm_bclk_src #(
    .BCLK_HALF(BCLK_HALF)
  ) i_bclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .slave    (slave),
    .ext_bclk (ext_bclk),
    .ext_fsync(ext_fsync),
    .bclk_q   (bclk_q),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .fs_smp   (fs_smp)
  );

  tdm_frame_ctr #(
    .DIV_W (DIV_W),
    .SLOT_W(SLOT_W)
  ) i_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .slave      (slave),
    .pol        (pol),
    .kind       (kind),
    .frame_div  (frame_div),
    .slot_len   (slot_len),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .fs_smp     (fs_smp),
    .bit_cnt    (bit_cnt_o),
    .fsync      (fsync_o),
    .frame_start(frame_start_o),
    .tx_shift   (tx_shift_o),
    .rx_sample  (rx_sample_o)
  );

  assign bclk_o         = bclk_q;
  assign port_drive_o   = active && !slave;
  assign config_error_o = cfg_err;
  assign tx_hiz_o       = hiz_req && !active;

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (config_error_o && $past(config_error_o)) |-> (!bclk_o && !fsync_o && bit_cnt_o == '0));

  // R10
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && $past(slave)) |-> (!bclk_o && !fsync_o && !port_drive_o));

endmodule

// File: tb/test_tdm_fsync_gen.sv
`timescale 1ns/1ps
module test_tdm_fsync_gen;

  localparam int DIV_W = 10, SLOT_W = 6, NSLOT_W = 4, HALF = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] ctrl_word;
  logic [DIV_W-1:0] frame_div;
  logic [SLOT_W-1:0] tx_slot_bits, rx_slot_bits;
  logic [NSLOT_W-1:0] tx_slots, rx_slots;
  logic ext_bclk, ext_fsync;
  logic bclk_o, fsync_o, port_drive_o, frame_start_o, tx_shift_o, rx_sample_o;
  logic config_error_o, tx_hiz_o;
  logic [DIV_W-1:0] bit_cnt_o;

  always #2 clk = ~clk;

  tdm_fsync_gen #(.DIV_W(DIV_W), .SLOT_W(SLOT_W), .NSLOT_W(NSLOT_W), .BCLK_HALF(HALF))
  i_tdm_fsync_gen (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .frame_div(frame_div),
    .tx_slot_bits(tx_slot_bits), .rx_slot_bits(rx_slot_bits),
    .tx_slots(tx_slots), .rx_slots(rx_slots),
    .ext_bclk(ext_bclk), .ext_fsync(ext_fsync),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .port_drive_o(port_drive_o),
    .frame_start_o(frame_start_o), .bit_cnt_o(bit_cnt_o),
    .tx_shift_o(tx_shift_o), .rx_sample_o(rx_sample_o),
    .config_error_o(config_error_o), .tx_hiz_o(tx_hiz_o)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit exp_err(input int div, input int sl, input int ns, input bit lng);
    return ((div + 1) < sl * ns) || (lng && ns <= 1 && (div + 1) <= sl);
  endfunction

  function automatic bit exp_fs(input int n, input int div, input int sl, input bit lng, input bit early);
    if (lng) return n < sl;
    if (early) return n == div;
    return n == 0;
  endfunction

  // master-mode monitor
  bit mon_on = 0, m_first = 0, m_pol = 0, m_lng = 0, m_early = 0;
  int m_div = 0, m_sl = 0, m_n = 0, cyc = 0;
  bit pb = 0;

  always @(negedge clk) begin
    bit rise, fall;
    string lab;
    if (mon_on) begin
      rise = bclk_o && !pb;
      fall = !bclk_o && pb;
      chk(tx_shift_o == (m_pol ? fall : rise), "R9 tx_shift", tx_shift_o, m_pol ? fall : rise);
      chk(rx_sample_o == (m_pol ? rise : fall), "R9 rx_sample", rx_sample_o, m_pol ? rise : fall);
      if (rise) begin
        if (m_first) begin
          m_n = 0;
          m_first = 0;
        end else begin
          chk(cyc == 2 * HALF, "R2 bclk period", cyc, 2 * HALF);
          m_n = (m_n == m_div) ? 0 : m_n + 1;
        end
        cyc = 0;
        chk(int'(bit_cnt_o) == m_n, "R3 bit_cnt", bit_cnt_o, m_n);
        chk(frame_start_o == (m_n == 0), "R3 frame_start", frame_start_o, m_n == 0);
        lab = m_lng ? "R6 long sync" : (m_early ? "R5 early sync" : "R4 late sync");
        chk(fsync_o == exp_fs(m_n, m_div, m_sl, m_lng, m_early), lab, fsync_o,
            exp_fs(m_n, m_div, m_sl, m_lng, m_early));
      end else begin
        chk(frame_start_o == 1'b0, "R3 frame_start off", frame_start_o, 0);
      end
      cyc++;
    end
    pb = bclk_o;
  end

  task automatic idle_check(input string req);
    chk(bclk_o == 0 && fsync_o == 0 && frame_start_o == 0 && bit_cnt_o == 0 &&
        tx_shift_o == 0 && rx_sample_o == 0 && port_drive_o == 0, req,
        {bclk_o, fsync_o, frame_start_o, tx_shift_o, rx_sample_o, port_drive_o}, 0);
  endtask

  task automatic run_master(input int div, input int txs, input int rxs, input int txn,
                            input int rxn, input bit lng, input bit early, input bit pol);
    int sl, ns;
    bit e;
    sl = imax(txs, rxs);
    ns = imax(txn, rxn);
    e = exp_err(div, sl, ns, lng);
    @(negedge clk);
    ctrl_word = 6'd0;
    repeat (3) @(negedge clk);
    frame_div = DIV_W'(div);
    tx_slot_bits = SLOT_W'(txs); rx_slot_bits = SLOT_W'(rxs);
    tx_slots = NSLOT_W'(txn); rx_slots = NSLOT_W'(rxn);
    ctrl_word = {pol, 1'b0, early, lng, 1'b0, 1'b0};
    repeat (3) @(negedge clk);
    chk(config_error_o == e, lng ? "R8 error flag" : "R7 error flag", config_error_o, e);
    if (e) begin
      ctrl_word[0] = 1'b1;
      repeat (40) @(negedge clk);
      idle_check("R7 idle on error");
      ctrl_word[0] = 1'b0;
    end else begin
      m_div = div; m_sl = sl; m_lng = lng; m_early = early; m_pol = pol;
      m_first = 1; cyc = 0;
      mon_on = 1;
      ctrl_word[0] = 1'b1;
      repeat (2 * (div + 1) * 2 * HALF + 2 * HALF + 4) @(negedge clk);
      mon_on = 0;
      ctrl_word[0] = 1'b0;
      repeat (3) @(negedge clk);
      idle_check("R1 idle after disable");
    end
  endtask

  // slave-mode frame start counter
  bit slv_on = 0;
  int fst_cnt = 0;
  always @(negedge clk) begin
    if (slv_on && frame_start_o) fst_cnt++;
  end

  task automatic run_slave(input int div, input int width, input int nbits);
    @(negedge clk);
    ctrl_word = 6'd0;
    ext_bclk = 0; ext_fsync = 0;
    frame_div = DIV_W'(div);
    tx_slot_bits = 6'd8; rx_slot_bits = 6'd8; tx_slots = 4'd2; rx_slots = 4'd2;
    repeat (4) @(negedge clk);
    ctrl_word = 6'b000011;
    fst_cnt = 0;
    slv_on = 1;
    for (int k = 0; k < nbits; k++) begin
      ext_bclk = 0;
      ext_fsync = ((k % (div + 1)) < width);
      repeat (8) @(negedge clk);
      ext_bclk = 1;
      repeat (6) @(negedge clk);
      chk(int'(bit_cnt_o) == k % (div + 1), "R10 slave bit_cnt", bit_cnt_o, k % (div + 1));
      chk(bclk_o == 0 && fsync_o == 0 && port_drive_o == 0, "R10 slave pins quiet",
          {bclk_o, fsync_o, port_drive_o}, 0);
      repeat (2) @(negedge clk);
    end
    slv_on = 0;
    chk(fst_cnt == nbits / (div + 1), "R10 frame start count", fst_cnt, nbits / (div + 1));
    ctrl_word = 6'd0;
    ext_bclk = 0; ext_fsync = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int sizes[3];
    int counts[5];
    int txs, rxs, txn, rxn, div;
    sizes = '{8, 16, 32};
    counts = '{1, 2, 4, 6, 8};
    void'($urandom(32'd20240611));
    rst_n = 0;
    ctrl_word = 6'd0; frame_div = '0;
    tx_slot_bits = 6'd8; rx_slot_bits = 6'd8; tx_slots = 4'd2; rx_slots = 4'd2;
    ext_bclk = 0; ext_fsync = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    idle_check("R1 reset state");
    chk(tx_hiz_o == 0, "R11 hiz at reset", tx_hiz_o, 0);

    // R11: float request while not running
    frame_div = 10'd15;
    ctrl_word = 6'b010000;
    @(negedge clk);
    chk(tx_hiz_o == 1, "R11 hiz when idle", tx_hiz_o, 1);
    ctrl_word = 6'b010001;
    repeat (3) @(negedge clk);
    chk(tx_hiz_o == 0, "R11 hiz when running", tx_hiz_o, 0);
    ctrl_word = 6'd0;
    repeat (3) @(negedge clk);

    // directed corner cases
    run_master(15, 8, 8, 2, 2, 0, 0, 0);   // R4 exact fit
    run_master(15, 8, 8, 2, 2, 0, 1, 1);   // R5, swapped polarity
    run_master(19, 8, 8, 2, 2, 1, 1, 0);   // R6 early ignored
    run_master(19, 8, 8, 2, 2, 1, 0, 0);   // R6
    run_master(14, 8, 8, 2, 1, 0, 0, 0);   // R7 one bit short
    run_master(15, 16, 8, 1, 1, 1, 0, 0);  // R8 long single slot, equal
    run_master(15, 16, 8, 1, 1, 0, 0, 0);  // R8 same in short mode
    run_master(16, 16, 8, 1, 1, 1, 0, 1);  // R8 one bit over
    run_master(63, 8, 32, 1, 2, 0, 0, 0);  // R7 max of each direction
    run_master(62, 8, 32, 1, 2, 0, 0, 0);  // R7 just short

    // constrained random
    for (int i = 0; i < 14; i++) begin
      txs = sizes[$urandom % 3]; rxs = sizes[$urandom % 3];
      txn = counts[$urandom % 5]; rxn = counts[$urandom % 5];
      div = imax(txs, rxs) * imax(txn, rxn) - 2 + int'($urandom % 6);
      run_master(div, txs, rxs, txn, rxn, $urandom % 2, $urandom % 2, $urandom % 2);
    end

    // slave: one-bit sync, then half-frame-wide sync
    run_slave(15, 1, 48);
    run_slave(15, 8, 48);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule